// File: doc/BRIEF.md
# Accumulator Byte ALU with Pair Multiply, Test and Sign Extend

This block does the byte arithmetic and logic of an accumulator-style processor. It takes one operand from the accumulator and one from a source byte that the surrounding datapath has already selected. It returns a byte result, a wide result, the new flag byte, and one write enable for each place a result can go. Beyond the usual add, subtract and logic operations it provides:
- increment and decrement of any byte;
- accumulator-only operations: decimal adjust, complement and negate;
- a nondestructive AND test;
- an 8x8 multiply that writes its 16-bit product back into the register pair it came from;
- a sign extension of the accumulator into a 16-bit or 32-bit HL.

All outputs are registered. The inputs present at a rising clock edge give the outputs seen after that edge. The block does no operand fetch, addressing or memory access.

Top module: `acc_alu`

## Requirements
- R1: The outputs change only on a rising clock edge and reflect the inputs sampled at that edge. While `rst` is high at an edge, every output becomes zero. Opcode codes: 0 NOP, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 AND, 6 OR, 7 XOR, 8 CP, 9 INC, 10 DEC, 11 CPL, 12 DAA, 13 NEG, 14 EXTS, 15 MLT, 16 TST.
- R2: ADD, ADC, SUB and SBC compute acc ± src (± incoming carry for ADC/SBC) modulo 256 and assert `wr_acc_o`. Flag bits are: S=7 (result bit 7), Z=6 (result zero), H=4 (carry or borrow out of bit 3), PV=2 (signed overflow), N=1 (1 for subtract), C=0 (carry or borrow out of bit 7). Bits 5 and 3 of `flags_o` are always 0.
- R3: AND, OR and XOR write acc op src to the accumulator. PV is set when the result has an even number of ones. H is 1 for AND and 0 for OR and XOR. N=0 and C=0.
- R4: CP sets the flags exactly as SUB would and shows the difference on `res_byte_o`, but asserts no write enable.
- R5: INC and DEC compute src+1 or src-1, assert `wr_dst_o` only, set S, Z, H, PV and N as an add or subtract of 1 would, and keep C equal to the incoming C.
- R6: CPL writes the bitwise inverse of acc and sets H=1 and N=1. S, Z, PV and C are copied from the incoming flags.
- R7: NEG writes 0-acc. C is 1 when acc was nonzero and PV is 1 when acc was 0x80. The other flags follow the subtract rules of R2.
- R8: DAA corrects acc to packed BCD. The correction gets 0x06 when the incoming H is set or the low nibble is above 9. It gets 0x60, and C is set, when the incoming C is set or acc is above 0x99; otherwise C keeps its incoming value. The correction is subtracted when the incoming N is set and added otherwise. N is kept. For an add, H is set when the low nibble was above 9; for a subtract, H is set when the incoming H was set and the low nibble was below 6. S, Z and even parity on PV come from the result.
- R9: TST sets the flags exactly as AND would, and shows the AND on `res_byte_o`, but asserts no write enable.
- R10: MLT multiplies bits 15..8 by bits 7..0 of `pair_i`. It puts the 16-bit product in `res_wide_o[15:0]` with zeros above and the low product byte on `res_byte_o`, and asserts `wr_pair_o`. Flags pass through.
- R11: EXTS puts acc sign-extended to 32 bits on `res_wide_o` and asserts `wr_hl_o`. `wr_hlx_o` (upper HL half) is asserted only when `long_mode_i` is 1. `res_byte_o` is acc and the flags pass through.
- R12: At most one of `wr_acc_o`, `wr_dst_o`, `wr_pair_o`, `wr_hl_o` is 1. NOP and the unused codes 17–31 assert no write enable, show acc on `res_byte_o`, and pass the flags through. Outside MLT and EXTS, `res_wide_o` is `res_byte_o` zero-extended. "Pass through" means `flags_i` with bits 5 and 3 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (R1) |
| acc_i | input | 8 | Accumulator operand |
| src_i | input | 8 | Selected source byte |
| pair_i | input | 16 | Register pair for multiply |
| long_mode_i | input | 1 | Long-word mode for sign extension |
| flags_i | input | 8 | Incoming flag byte |
| res_byte_o | output | 8 | Byte result |
| res_wide_o | output | 32 | Wide result (product or sign extension) |
| wr_acc_o | output | 1 | Write the byte result to the accumulator |
| wr_dst_o | output | 1 | Write the byte result to the increment/decrement target |
| wr_pair_o | output | 1 | Write the product to the register pair |
| wr_hl_o | output | 1 | Write bits 15..0 of the wide result to HL |
| wr_hlx_o | output | 1 | Write bits 31..16 of the wide result to the upper HL half |
| flags_o | output | 8 | New flag byte |

## Verification
The arithmetic and compare opcodes are swept over every accumulator value against a strided set of sources, with the incoming flag byte changing from step to step. This separates carry-in use, half-carry, overflow and borrow, and shows that stale incoming flags are replaced. Increment, decrement, complement and negate each cover the full byte range, which reaches the 0x7F/0x80 overflow edges and the zero case of negate. Decimal adjust runs every byte under all eight H/N/C combinations. Multiply runs a strided set of pairs, sign extension runs every byte in both modes, and NOP and unused codes run with arbitrary flags to show that nothing is written.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int LONG_W = 4 * BYTE_W;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADC  = 5'd2,
        OP_SUB  = 5'd3,
        OP_SBC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CP   = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_CPL  = 5'd11,
        OP_DAA  = 5'd12,
        OP_NEG  = 5'd13,
        OP_EXTS = 5'd14,
        OP_MLT  = 5'd15,
        OP_TST  = 5'd16
    } alu_op_e;

    // Flag byte, bit 7 down to bit 0.
    typedef struct packed {
        logic s;
        logic z;
        logic u5;
        logic h;
        logic u3;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [LONG_W-1:0] wide;
        logic [BYTE_W-1:0] byte_r;
        flags_t            fl;
        logic              wr_acc;
        logic              wr_dst;
        logic              wr_pair;
        logic              wr_hl;
        logic              wr_hlx;
    } alu_out_t;

    function automatic logic even_par(input logic [BYTE_W-1:0] v);
        return ~^v;
    endfunction

    function automatic flags_t szp_flags(input logic [BYTE_W-1:0] v);
        flags_t f;
        f    = '0;
        f.s  = v[BYTE_W-1];
        f.z  = (v == '0);
        f.pv = even_par(v);
        return f;
    endfunction

endpackage

// File: rtl/accalu_addsub.sv
module accalu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         carry_o,
    output logic         half_o,
    output logic         ovf_o
);
    localparam int HW = W / 2;

    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   full;
    logic [HW:0]  low;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        c0      = sub_i ^ cin_i;
        full    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        low     = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, c0};
        sum_o   = full[W-1:0];
        carry_o = full[W] ^ sub_i;
        half_o  = low[HW] ^ sub_i;
        ovf_o   = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/accalu_logic.sv
module accalu_logic
    import accalu_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    output logic [BYTE_W-1:0] res_o,
    output flags_t            fl_o
);
    always_comb begin
        case (op_i)
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i & b_i;
        endcase
        fl_o   = szp_flags(res_o);
        fl_o.h = (op_i == OP_AND) || (op_i == OP_TST);
    end
endmodule

// File: rtl/accalu_bcd.sv
module accalu_bcd
    import accalu_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  flags_t            fl_i,
    output logic [BYTE_W-1:0] res_o,
    output flags_t            fl_o
);
    logic [BYTE_W-1:0] corr;
    logic              cy;
    logic              lo_big;

    always_comb begin
        lo_big = (a_i[3:0] > 4'd9);
        corr   = '0;
        cy     = fl_i.c;
        if (fl_i.h || lo_big) corr[3:0] = 4'h6;
        if (fl_i.c || (a_i > 8'h99)) begin
            corr[7:4] = 4'h6;
            cy        = 1'b1;
        end
        res_o  = fl_i.n ? (a_i - corr) : (a_i + corr);
        fl_o   = szp_flags(res_o);
        fl_o.n = fl_i.n;
        fl_o.c = cy;
        fl_o.h = fl_i.n ? (fl_i.h && (a_i[3:0] < 4'd6)) : lo_big;
    end
endmodule

// File: rtl/accalu_wide.sv
module accalu_wide #(
    parameter int AW = 8,
    parameter int PW = 16,
    parameter int LW = 32
) (
    input  logic [PW-1:0] pair_i,
    input  logic [AW-1:0] acc_i,
    output logic [PW-1:0] prod_o,
    output logic [LW-1:0] sext_o
);
    localparam int HW = PW / 2;

    always_comb begin
        prod_o = {{HW{1'b0}}, pair_i[PW-1:HW]} * {{HW{1'b0}}, pair_i[HW-1:0]};
        sext_o = {{(LW-AW){acc_i[AW-1]}}, acc_i};
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import accalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [BYTE_W-1:0] acc_i,
    input  logic [BYTE_W-1:0] src_i,
    input  logic [PAIR_W-1:0] pair_i,
    input  logic              long_mode_i,
    input  logic [BYTE_W-1:0] flags_i,
    output logic [BYTE_W-1:0] res_byte_o,
    output logic [LONG_W-1:0] res_wide_o,
    output logic              wr_acc_o,
    output logic              wr_dst_o,
    output logic              wr_pair_o,
    output logic              wr_hl_o,
    output logic              wr_hlx_o,
    output logic [BYTE_W-1:0] flags_o
);
    alu_op_e op;
    flags_t  fin;
    assign op  = alu_op_e'(op_i);
    assign fin = flags_t'(flags_i);

    // Shared adder: operand steering
    logic [BYTE_W-1:0] add_a, add_b, add_sum;
    logic              add_cin, add_sub, add_c, add_h, add_v;

    always_comb begin
        add_a   = acc_i;
        add_b   = src_i;
        add_cin = 1'b0;
        add_sub = 1'b0;
        case (op)
            OP_ADC: add_cin = fin.c;
            OP_SUB, OP_CP: add_sub = 1'b1;
            OP_SBC: begin
                add_sub = 1'b1;
                add_cin = fin.c;
            end
            OP_INC: begin
                add_a = src_i;
                add_b = BYTE_W'(1);
            end
            OP_DEC: begin
                add_a   = src_i;
                add_b   = BYTE_W'(1);
                add_sub = 1'b1;
            end
            OP_NEG: begin
                add_a   = '0;
                add_b   = acc_i;
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    accalu_addsub #(.W(BYTE_W)) u_add (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sub_i  (add_sub),
        .sum_o  (add_sum),
        .carry_o(add_c),
        .half_o (add_h),
        .ovf_o  (add_v)
    );

    flags_t af;
    always_comb begin
        af    = '0;
        af.s  = add_sum[BYTE_W-1];
        af.z  = (add_sum == '0);
        af.h  = add_h;
        af.pv = add_v;
        af.n  = add_sub;
        af.c  = add_c;
    end

    logic [BYTE_W-1:0] log_res;
    flags_t            log_fl;
    accalu_logic u_log (
        .op_i (op),
        .a_i  (acc_i),
        .b_i  (src_i),
        .res_o(log_res),
        .fl_o (log_fl)
    );

    logic [BYTE_W-1:0] bcd_res;
    flags_t            bcd_fl;
    accalu_bcd u_bcd (
        .a_i  (acc_i),
        .fl_i (fin),
        .res_o(bcd_res),
        .fl_o (bcd_fl)
    );

    logic [PAIR_W-1:0] prod;
    logic [LONG_W-1:0] sext;
    accalu_wide #(.AW(BYTE_W), .PW(PAIR_W), .LW(LONG_W)) u_wide (
        .pair_i(pair_i),
        .acc_i (acc_i),
        .prod_o(prod),
        .sext_o(sext)
    );

    // Result selection and write-enable decode
    alu_out_t nxt, cur;
    always_comb begin
        nxt        = '0;
        nxt.byte_r = acc_i;
        nxt.fl     = fin;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
                nxt.byte_r = add_sum;
                nxt.fl     = af;
                nxt.wr_acc = 1'b1;
            end
            OP_CP: begin
                nxt.byte_r = add_sum;
                nxt.fl     = af;
            end
            OP_INC, OP_DEC: begin
                nxt.byte_r = add_sum;
                nxt.fl     = af;
                nxt.fl.c   = fin.c;
                nxt.wr_dst = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt.byte_r = log_res;
                nxt.fl     = log_fl;
                nxt.wr_acc = 1'b1;
            end
            OP_TST: begin
                nxt.byte_r = log_res;
                nxt.fl     = log_fl;
            end
            OP_CPL: begin
                nxt.byte_r = ~acc_i;
                nxt.fl.h   = 1'b1;
                nxt.fl.n   = 1'b1;
                nxt.wr_acc = 1'b1;
            end
            OP_DAA: begin
                nxt.byte_r = bcd_res;
                nxt.fl     = bcd_fl;
                nxt.wr_acc = 1'b1;
            end
            OP_MLT: begin
                nxt.byte_r  = prod[BYTE_W-1:0];
                nxt.wr_pair = 1'b1;
            end
            OP_EXTS: begin
                nxt.wr_hl  = 1'b1;
                nxt.wr_hlx = long_mode_i;
            end
            default: ;
        endcase
        case (op)
            OP_MLT:  nxt.wide = {{(LONG_W-PAIR_W){1'b0}}, prod};
            OP_EXTS: nxt.wide = sext;
            default: nxt.wide = {{(LONG_W-BYTE_W){1'b0}}, nxt.byte_r};
        endcase
        nxt.fl.u5 = 1'b0;
        nxt.fl.u3 = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign res_byte_o = cur.byte_r;
    assign res_wide_o = cur.wide;
    assign flags_o    = cur.fl;
    assign wr_acc_o   = cur.wr_acc;
    assign wr_dst_o   = cur.wr_dst;
    assign wr_pair_o  = cur.wr_pair;
    assign wr_hl_o    = cur.wr_hl;
    assign wr_hlx_o   = cur.wr_hlx;

    // One clean cycle since reset, so $past sees sampled inputs
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_acc_o, wr_dst_o, wr_pair_o, wr_hl_o})); // R12
    AST_HLX_NEEDS_HL: assert property (@(posedge clk) disable iff (rst)
        wr_hlx_o |-> wr_hl_o); // R11
    AST_CP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(op_i) == OP_CP) |-> (!wr_acc_o && flags_o[1])); // R4
    AST_TST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(op_i) == OP_TST) |-> (!wr_acc_o && !wr_dst_o && flags_o[4] && !flags_o[0])); // R9
    AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(op_i) == OP_NEG) |-> (flags_o[0] == ($past(acc_i) != 8'd0))); // R7
    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (rst)
        (past_ok && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC)) |-> (flags_o[0] == $past(flags_i[0]))); // R5
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op_i;
    logic [7:0]  acc_i, src_i, flags_i;
    logic [15:0] pair_i;
    logic        long_mode_i;
    logic [7:0]  res_byte_o, flags_o;
    logic [31:0] res_wide_o;
    logic        wr_acc_o, wr_dst_o, wr_pair_o, wr_hl_o, wr_hlx_o;

    always #10 clk = ~clk; // 50 MHz

    acc_alu u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .src_i(src_i),
        .pair_i(pair_i), .long_mode_i(long_mode_i), .flags_i(flags_i),
        .res_byte_o(res_byte_o), .res_wide_o(res_wide_o),
        .wr_acc_o(wr_acc_o), .wr_dst_o(wr_dst_o), .wr_pair_o(wr_pair_o),
        .wr_hl_o(wr_hl_o), .wr_hlx_o(wr_hlx_o), .flags_o(flags_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic int sx(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    function automatic int szp(input int r);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (r >> i) & 1;
        return (r & 128) + ((r == 0) ? 64 : 0) + ((c % 2 == 0) ? 4 : 0);
    endfunction

    task automatic arith(input int a, input int b, input int ci, input int sub,
                         output int r, output int f);
        int raw, hh, sv;
        if (sub != 0) begin
            raw = a - b - ci; hh = (a & 15) - (b & 15) - ci; sv = sx(a) - sx(b) - ci;
        end else begin
            raw = a + b + ci; hh = (a & 15) + (b & 15) + ci; sv = sx(a) + sx(b) + ci;
        end
        r = raw & 255;
        f = (r & 128) + ((r == 0) ? 64 : 0)
          + (((sub != 0) ? (hh < 0) : (hh > 15)) ? 16 : 0)
          + ((sv > 127 || sv < -128) ? 4 : 0)
          + ((sub != 0) ? 2 : 0)
          + (((sub != 0) ? (raw < 0) : (raw > 255)) ? 1 : 0);
    endtask

    // ewr bits: 4 acc, 3 dst, 2 pair, 1 hl, 0 hlx
    task automatic model(input int op, input int a, input int s, input int pr,
                         input int lm, input int fi,
                         output int eb, output logic [31:0] ew, output int ef, output int ewr);
        int ci, f, lo, hf, nf, cf, corr, cout, r;
        ci = fi & 1;
        eb = a; ef = fi & 8'hD7; ewr = 0;
        case (op)
            1: begin arith(a, s, 0, 0, eb, ef); ewr = 16; end
            2: begin arith(a, s, ci, 0, eb, ef); ewr = 16; end
            3: begin arith(a, s, 0, 1, eb, ef); ewr = 16; end
            4: begin arith(a, s, ci, 1, eb, ef); ewr = 16; end
            5, 16: begin eb = a & s; ef = szp(eb) + 16; ewr = (op == 5) ? 16 : 0; end
            6: begin eb = a | s; ef = szp(eb); ewr = 16; end
            7: begin eb = a ^ s; ef = szp(eb); ewr = 16; end
            8: begin arith(a, s, 0, 1, eb, ef); end
            9:  begin arith(s, 1, 0, 0, eb, f); ef = (f & 8'hFE) | ci; ewr = 8; end
            10: begin arith(s, 1, 0, 1, eb, f); ef = (f & 8'hFE) | ci; ewr = 8; end
            11: begin eb = (~a) & 255; ef = (fi & 8'hC5) | 8'h12; ewr = 16; end
            12: begin
                lo = a & 15; hf = (fi >> 4) & 1; nf = (fi >> 1) & 1; cf = ci;
                corr = 0; cout = cf;
                if (hf != 0 || lo > 9) corr += 6;
                if (cf != 0 || a > 153) begin corr += 96; cout = 1; end
                r = (nf != 0) ? ((a - corr) & 255) : ((a + corr) & 255);
                eb = r;
                ef = szp(r) + (((nf != 0) ? (hf != 0 && lo < 6) : (lo > 9)) ? 16 : 0)
                   + nf * 2 + cout;
                ewr = 16;
            end
            13: begin arith(0, a, 0, 1, eb, ef); ewr = 16; end
            14: ewr = 2 + lm;
            15: ewr = 4;
            default: ;
        endcase
        if (op == 15) begin
            ew = 32'(((pr >> 8) & 255) * (pr & 255));
            eb = int'(ew[7:0]);
        end else if (op == 14) begin
            ew = (a > 127) ? (32'hFFFFFF00 | 32'(a)) : 32'(a);
        end else begin
            ew = 32'(eb);
        end
    endtask

    task automatic run(input int op, input int a, input int s, input int pr,
                       input int lm, input int fi, input string req);
        int eb, ef, ewr;
        logic [31:0] ew;
        model(op, a, s, pr, lm, fi, eb, ew, ef, ewr);
        op_i = 5'(op); acc_i = 8'(a); src_i = 8'(s); pair_i = 16'(pr);
        long_mode_i = lm[0]; flags_i = 8'(fi);
        @(negedge clk);
        n_chk++;
        if (res_byte_o !== eb[7:0] || res_wide_o !== ew || flags_o !== ef[7:0] ||
            {wr_acc_o, wr_dst_o, wr_pair_o, wr_hl_o, wr_hlx_o} !== ewr[4:0]) begin
            n_bad++;
            $display("FAIL %s op=%0d a=%h s=%h pr=%h lm=%0d fi=%h: actual byte=%h wide=%h fl=%h wr=%b expected byte=%h wide=%h fl=%h wr=%b",
                     req, op, a[7:0], s[7:0], pr[15:0], lm, fi[7:0],
                     res_byte_o, res_wide_o, flags_o,
                     {wr_acc_o, wr_dst_o, wr_pair_o, wr_hl_o, wr_hlx_o},
                     eb[7:0], ew, ef[7:0], ewr[4:0]);
        end
    endtask

    task automatic check_reset_state();
        n_chk++;
        if (res_byte_o !== 8'h00 || res_wide_o !== 32'h0 || flags_o !== 8'h00 ||
            {wr_acc_o, wr_dst_o, wr_pair_o, wr_hl_o, wr_hlx_o} !== 5'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual byte=%h wide=%h fl=%h wr=%b expected all zero",
                     res_byte_o, res_wide_o, flags_o,
                     {wr_acc_o, wr_dst_o, wr_pair_o, wr_hl_o, wr_hlx_o});
        end
    endtask

    initial begin
        #(250000 * 20);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_i = 5'd13; acc_i = 8'h5A; src_i = 8'hFF;
        pair_i = 16'hFFFF; long_mode_i = 1'b1; flags_i = 8'hFF;
        repeat (3) @(negedge clk);
        check_reset_state(); // R1: reset state despite nonzero inputs
        rst = 1'b0;

        // R2 / R3 / R4 / R9: accumulator-vs-source sweeps
        for (int op = 1; op <= 8; op++)
            for (int a = 0; a < 256; a++)
                for (int s = 0; s < 256; s += 15)
                    run(op, a, s, 0, 0, (a ^ (s * 3)) & 255,
                        (op <= 4) ? "R2" : (op == 8) ? "R4" : "R3");
        for (int a = 0; a < 256; a++)
            for (int s = 0; s < 256; s += 15)
                run(16, a, s, 0, 0, (a * 7 + s) & 255, "R9");

        // R5: increment / decrement over the full byte range, both carry values
        for (int s = 0; s < 256; s++) begin
            run(9, s ^ 8'h33, s, 0, 0, s ^ 8'h5A, "R5");
            run(9, s, s, 0, 0, s ^ 8'hA5, "R5");
            run(10, s ^ 8'h33, s, 0, 0, s ^ 8'h5A, "R5");
            run(10, s, s, 0, 0, s ^ 8'hA5, "R5");
        end

        // R6 / R7: complement and negate
        for (int a = 0; a < 256; a++) begin
            run(11, a, 0, 0, 0, 8'hFF, "R6");
            run(11, a, 0, 0, 0, a, "R6");
            run(13, a, a, 0, 0, 8'h00, "R7");
            run(13, a, 0, 0, 0, 8'hFF, "R7");
        end

        // R8: decimal adjust under every H/N/C combination
        for (int k = 0; k < 8; k++)
            for (int a = 0; a < 256; a++)
                run(12, a, 0, 0, 0, ((k & 4) ? 16 : 0) + ((k & 2) ? 2 : 0) + (k & 1) + 8'hC0, "R8");

        // R10: pair multiply
        for (int hi = 0; hi < 256; hi++)
            for (int lo = 0; lo < 256; lo += 7)
                run(15, hi, lo, hi * 256 + lo, 0, (hi + lo) & 255, "R10");
        run(15, 0, 0, 16'hFFFF, 1, 8'hFF, "R10");

        // R11: sign extension in both modes
        for (int a = 0; a < 256; a++) begin
            run(14, a, 0, 0, 0, a, "R11");
            run(14, a, 0, 0, 1, 255 - a, "R11");
        end

        // R12: NOP and unused codes write nothing and pass flags
        for (int a = 0; a < 256; a++) begin
            run(0, a, 255 - a, 16'h1234, 1, a, "R12");
            run(17, a, a, 16'hFFFF, 1, 255 - a, "R12");
            run(31, a, 0, 16'h0F0F, 0, a ^ 8'h28, "R12");
        end

        // R1: reset in the middle of activity
        op_i = 5'd1; acc_i = 8'hFF; src_i = 8'h01; flags_i = 8'hFF;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state(); // R1
        rst = 1'b0;
        run(2, 8'h7F, 8'h00, 0, 0, 8'h01, "R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule